// File: doc/BRIEF.md
# Indirect Shared-RAM Host Window

This block lets a host processor reach a coprocessor's byte-wide shared RAM without mapping that RAM into the host address space. The host sees four byte registers. Two of them load a 16-bit RAM pointer, one byte at a time. A third is a data window that reads or writes the RAM byte the pointer selects. The fourth is a combined control and status register.

The pointer can advance by one after every data access, so a run of bytes can be streamed through the data window. It wraps from the top of the address space back to zero. The control register holds three levels for the coprocessor: run, pass-through (bypass) and auto-increment. It also holds a doorbell bit that signals the coprocessor and stays up until the coprocessor acknowledges it.

The coprocessor raises two host interrupt flags with set strobes. Both flags drive one host interrupt line. The host clears each flag by writing a one to its bit, and the same write also updates the control levels.

Top module: `shram_window_port`

## Requirements
- R1: After reset, run, bypass, auto-increment, the doorbell, both interrupt flags, the host interrupt line, the read-valid output and the RAM pointer are all zero.
- R2: A host write to register 0 loads pointer bits 7:0, and a write to register 1 loads pointer bits 15:8. The new pointer appears on `ramAddr` in the next cycle and is used by the next data access.
- R3: A host access to register 2 drives `ramEn` with `ramAddr` equal to the pointer. On a write, `ramWe` is set and `ramWdata` equals the host byte. On a read, the RAM byte is returned on `hostRdata` in the following cycle.
- R4: When auto-increment (control bit 1) is set, every data-window access advances the pointer by one, and 0xFFFF wraps to 0x0000.
- R5: When auto-increment is clear, data-window accesses leave the pointer unchanged.
- R6: A host write to register 3 sets run (bit 0), auto-increment (bit 1) and bypass (bit 2) to the written bit values. `runOut` and `bypassOut` follow these bits.
- R7: Writing register 3 with bit 3 set raises `doorbell` in the next cycle. Writing bit 3 as zero leaves it unchanged. An asserted `doorbellAck` lowers it in the next cycle, but a doorbell write in the same cycle wins over the acknowledge.
- R8: `setInt0` sets flag 0 (bit 4) and `setInt1` sets flag 1 (bit 5). Writing a one to either bit in register 3 clears that flag, and writing a zero has no effect. A set strobe wins over a clear in the same cycle.
- R9: `hostIrq` is high exactly when at least one of the two interrupt flags is set.
- R10: Every host read produces `hostRvalid` for one cycle, in the cycle after the request. Registers 0 and 1 return the pointer bytes. Register 3 returns {2'b00, flag1, flag0, doorbell, bypass, auto-increment, run}, with run in bit 0, using the values held before the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access request this cycle |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostReg | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control/status |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read byte, valid with hostRvalid |
| hostRvalid | output | 1 | Read data valid, one cycle after the request |
| hostIrq | output | 1 | Host interrupt line (OR of the two flags) |
| ramAddr | output | 16 | Shared-RAM address (the current pointer) |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramWdata | output | 8 | RAM write byte |
| ramRdata | input | 8 | RAM read byte, one cycle after ramEn |
| runOut | output | 1 | Coprocessor run level |
| bypassOut | output | 1 | Peripheral pass-through level |
| doorbell | output | 1 | Doorbell toward the coprocessor |
| doorbellAck | input | 1 | Coprocessor acknowledge of the doorbell |
| setInt0 | input | 1 | Coprocessor set strobe for flag 0 |
| setInt1 | input | 1 | Coprocessor set strobe for flag 1 |

## Verification
The hardest cases to reach are the collisions. The first is a coprocessor set strobe arriving in the same cycle as a host write-one-to-clear of the same flag. The second is a doorbell write landing on the cycle of an acknowledge. The third is the pointer crossing 0xFFFF while streaming. Directed sequences place each of these collisions on a chosen cycle: the pointer is preloaded to 0xFFFE before a three-byte burst, and set, clear and acknowledge are driven together. A long random mix then drives strobes, acknowledges and host accesses freely against the cycle model, so these collisions also occur in combinations that were not scripted.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [1:0] {
    REG_PTR_LO = 2'd0,
    REG_PTR_HI = 2'd1,
    REG_DATA   = 2'd2,
    REG_CTRL   = 2'd3
  } regSel_e;

  localparam int BIT_RUN   = 0;
  localparam int BIT_AUTO  = 1;
  localparam int BIT_BYP   = 2;
  localparam int BIT_BELL  = 3;
  localparam int BIT_FLAG0 = 4;
  localparam int BIT_FLAG1 = 5;
  localparam int CTRL_USED = 6;

  typedef struct packed {
    logic    loadLo;
    logic    loadHi;
    logic    dataAcc;
    logic    dataWr;
    logic    rdReq;
    regSel_e rdSel;
  } dpStrobe_t;
endpackage

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostSel,
  input  logic                 hostWe,
  input  logic [1:0]           hostReg,
  input  logic [CTRL_USED-1:0] ctrlWdata,
  input  logic                 doorbellAck,
  input  logic                 setInt0,
  input  logic                 setInt1,
  output dpStrobe_t            stb,
  output logic [DATA_W-1:0]    ctrlByte,
  output logic                 runOn,
  output logic                 autoOn,
  output logic                 bypassOn,
  output logic                 bellOn,
  output logic                 flag0,
  output logic                 flag1
);
  regSel_e selReg;
  logic    ctrlWr;

  assign selReg = regSel_e'(hostReg);
  assign ctrlWr = hostSel && hostWe && (selReg == REG_CTRL);

  always_comb begin
    stb.loadLo  = hostSel && hostWe && (selReg == REG_PTR_LO);
    stb.loadHi  = hostSel && hostWe && (selReg == REG_PTR_HI);
    stb.dataAcc = hostSel && (selReg == REG_DATA);
    stb.dataWr  = hostSel && hostWe && (selReg == REG_DATA);
    stb.rdReq   = hostSel && !hostWe;
    stb.rdSel   = selReg;
  end

  // control levels follow the written bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runOn    <= 1'b0;
      autoOn   <= 1'b0;
      bypassOn <= 1'b0;
    end else if (ctrlWr) begin
      runOn    <= ctrlWdata[BIT_RUN];
      autoOn   <= ctrlWdata[BIT_AUTO];
      bypassOn <= ctrlWdata[BIT_BYP];
    end
  end

  // doorbell: host set beats coprocessor acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            bellOn <= 1'b0;
    else if (ctrlWr && ctrlWdata[BIT_BELL]) bellOn <= 1'b1;
    else if (doorbellAck)                 bellOn <= 1'b0;
  end

  // host flags: set strobe beats write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      if (setInt0)                              flag0 <= 1'b1;
      else if (ctrlWr && ctrlWdata[BIT_FLAG0])  flag0 <= 1'b0;
      if (setInt1)                              flag1 <= 1'b1;
      else if (ctrlWr && ctrlWdata[BIT_FLAG1])  flag1 <= 1'b0;
    end
  end

  always_comb begin
    ctrlByte            = '0;
    ctrlByte[BIT_RUN]   = runOn;
    ctrlByte[BIT_AUTO]  = autoOn;
    ctrlByte[BIT_BYP]   = bypassOn;
    ctrlByte[BIT_BELL]  = bellOn;
    ctrlByte[BIT_FLAG0] = flag0;
    ctrlByte[BIT_FLAG1] = flag1;
  end
endmodule

// File: rtl/shram_dp.sv
module shram_dp
  import shram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              autoOn,
  input  logic [DATA_W-1:0] ctrlByte,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramEn,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rdHold;
  logic              rdFromRam;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       ptr <= '0;
    else if (stb.loadLo)             ptr[DATA_W-1:0] <= hostWdata;
    else if (stb.loadHi)             ptr[ADDR_W-1:DATA_W] <= hostWdata[HI_W-1:0];
    else if (stb.dataAcc && autoOn)  ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRvalid <= 1'b0;
      rdFromRam  <= 1'b0;
      rdHold     <= '0;
    end else begin
      hostRvalid <= stb.rdReq;
      rdFromRam  <= stb.rdReq && (stb.rdSel == REG_DATA);
      if (stb.rdReq) begin
        case (stb.rdSel)
          REG_PTR_LO: rdHold <= ptr[DATA_W-1:0];
          REG_PTR_HI: rdHold <= DATA_W'(ptr[ADDR_W-1:DATA_W]);
          REG_CTRL:   rdHold <= ctrlByte;
          default:    rdHold <= '0;
        endcase
      end
    end
  end

  assign ramAddr   = ptr;
  assign ramEn     = stb.dataAcc;
  assign ramWe     = stb.dataWr;
  assign ramWdata  = hostWdata;
  assign hostRdata = rdFromRam ? ramRdata : rdHold;
endmodule

// File: rtl/shram_window_port.sv
module shram_window_port
  import shram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [1:0]        hostReg,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic              hostIrq,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramEn,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              runOut,
  output logic              bypassOut,
  output logic              doorbell,
  input  logic              doorbellAck,
  input  logic              setInt0,
  input  logic              setInt1
);
  dpStrobe_t         stb;
  logic [DATA_W-1:0] ctrlByte;
  logic              autoOn;
  logic              flag0;
  logic              flag1;

  shram_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWe     (hostWe),
    .hostReg    (hostReg),
    .ctrlWdata  (hostWdata[CTRL_USED-1:0]),
    .doorbellAck(doorbellAck),
    .setInt0    (setInt0),
    .setInt1    (setInt1),
    .stb        (stb),
    .ctrlByte   (ctrlByte),
    .runOn      (runOut),
    .autoOn     (autoOn),
    .bypassOn   (bypassOut),
    .bellOn     (doorbell),
    .flag0      (flag0),
    .flag1      (flag1)
  );

  shram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .autoOn    (autoOn),
    .ctrlByte  (ctrlByte),
    .hostWdata (hostWdata),
    .ramRdata  (ramRdata),
    .ramAddr   (ramAddr),
    .ramEn     (ramEn),
    .ramWe     (ramWe),
    .ramWdata  (ramWdata),
    .hostRdata (hostRdata),
    .hostRvalid(hostRvalid)
  );

  assign hostIrq = flag0 | flag1;
endmodule

// File: rtl/shram_window_chk.sv
module shram_window_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostSel,
  input logic              hostWe,
  input logic [1:0]        hostReg,
  input logic              bellBit,
  input logic              autoOn,
  input logic              doorbell,
  input logic              doorbellAck,
  input logic              setInt0,
  input logic              setInt1,
  input logic              hostIrq,
  input logic              hostRvalid,
  input logic [ADDR_W-1:0] ramAddr
);
  logic dataAcc;
  logic bellWr;
  assign dataAcc = hostSel && (hostReg == 2'd2);
  assign bellWr  = hostSel && hostWe && (hostReg == 2'd3) && bellBit;

  // R4
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc && autoOn |=> ramAddr == $past(ramAddr) + 1'b1);

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc && !autoOn |=> $stable(ramAddr));

  // R7
  bell_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    bellWr |=> doorbell);

  // R7
  bell_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    doorbellAck && !bellWr |=> !doorbell);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    setInt0 || setInt1 |=> hostIrq);

  // R10
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostSel && !hostWe |=> hostRvalid);

  // R10
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostSel && !hostWe) |=> !hostRvalid);
endmodule

bind shram_window_port shram_window_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .hostSel    (hostSel),
  .hostWe     (hostWe),
  .hostReg    (hostReg),
  .bellBit    (hostWdata[3]),
  .autoOn     (autoOn),
  .doorbell   (doorbell),
  .doorbellAck(doorbellAck),
  .setInt0    (setInt0),
  .setInt1    (setInt1),
  .hostIrq    (hostIrq),
  .hostRvalid (hostRvalid),
  .ramAddr    (ramAddr)
);

// File: tb/shram_window_port_tb.sv
`timescale 1ns/100ps
module shram_window_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWe = 1'b0;
  logic [1:0]  hostReg = 2'd0;
  logic [7:0]  hostWdata = 8'h00;
  logic [7:0]  hostRdata;
  logic        hostRvalid, hostIrq;
  logic [15:0] ramAddr;
  logic        ramEn, ramWe;
  logic [7:0]  ramWdata;
  logic [7:0]  ramRdata = 8'h00;
  logic        runOut, bypassOut, doorbell;
  logic        doorbellAck = 1'b0, setInt0 = 1'b0, setInt1 = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shram_window_port dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostReg(hostReg), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .hostIrq(hostIrq), .ramAddr(ramAddr),
    .ramEn(ramEn), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .runOut(runOut), .bypassOut(bypassOut), .doorbell(doorbell),
    .doorbellAck(doorbellAck), .setInt0(setInt0), .setInt1(setInt1)
  );

  // bench RAM driven from the port pins
  logic [7:0] tbRam [int];
  always @(posedge clk) begin
    if (ramEn) begin
      if (ramWe) tbRam[int'(ramAddr)] = ramWdata;
      else ramRdata <= tbRam.exists(int'(ramAddr)) ? tbRam[int'(ramAddr)] : 8'h00;
    end
  end

  // behavioural reference model
  logic [7:0] mMem [int];
  int  mPtr = 0;
  bit  mRun = 0, mAuto = 0, mByp = 0, mBell = 0, mF0 = 0, mF1 = 0, mRv = 0;
  int  mRd = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = 0; mRun = 0; mAuto = 0; mByp = 0; mBell = 0; mF0 = 0; mF1 = 0; mRv = 0;
    end else begin
      bit ctlW, nBell, nF0, nF1;
      int nPtr;
      ctlW = hostSel && hostWe && hostReg == 2'd3;
      nPtr = mPtr;
      mRv = hostSel && !hostWe;
      if (hostSel && !hostWe) begin
        case (hostReg)
          2'd0: mRd = mPtr % 256;
          2'd1: mRd = mPtr / 256;
          2'd2: mRd = mMem.exists(mPtr) ? int'(mMem[mPtr]) : 0;
          default: mRd = mRun + 2*mAuto + 4*mByp + 8*mBell + 16*mF0 + 32*mF1;
        endcase
      end
      if (hostSel && hostWe && hostReg == 2'd0) nPtr = (mPtr / 256) * 256 + hostWdata;
      if (hostSel && hostWe && hostReg == 2'd1) nPtr = hostWdata * 256 + mPtr % 256;
      if (hostSel && hostReg == 2'd2) begin
        if (hostWe) mMem[mPtr] = hostWdata;
        if (mAuto) nPtr = (mPtr + 1) % 65536;
      end
      nBell = mBell;
      if (doorbellAck) nBell = 0;
      if (ctlW && hostWdata[3]) nBell = 1;
      nF0 = setInt0 ? 1 : ((ctlW && hostWdata[4]) ? 0 : mF0);
      nF1 = setInt1 ? 1 : ((ctlW && hostWdata[5]) ? 0 : mF1);
      if (ctlW) begin mRun = hostWdata[0]; mAuto = hostWdata[1]; mByp = hostWdata[2]; end
      mBell = nBell; mF0 = nF0; mF1 = nF1; mPtr = nPtr;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) if (!done) begin
    chk("R2 R4 R5 ramAddr", int'(ramAddr), mPtr);
    chk("R6 runOut", int'(runOut), int'(mRun));
    chk("R6 bypassOut", int'(bypassOut), int'(mByp));
    chk("R7 doorbell", int'(doorbell), int'(mBell));
    chk("R8 R9 hostIrq", int'(hostIrq), int'(mF0 | mF1));
    chk("R10 hostRvalid", int'(hostRvalid), int'(mRv));
    if (hostRvalid && mRv) chk("R3 R10 hostRdata", int'(hostRdata), mRd);
  end

  task automatic drive(bit sel, bit we, int rg, int wd, bit s0 = 0, bit s1 = 0, bit ack = 0);
    @(negedge clk); #1;
    hostSel = sel; hostWe = we; hostReg = rg[1:0]; hostWdata = wd[7:0];
    setInt0 = s0; setInt1 = s1; doorbellAck = ack;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 reset hostIrq", int'(hostIrq), 0);
    chk("R1 reset ramAddr", int'(ramAddr), 0);
    @(negedge clk); #1 rstN = 1'b1;
    idle(2);
    // R4: auto-increment stream across the top of the address space
    drive(1, 1, 3, 8'h02);
    drive(1, 1, 0, 8'hFE);
    drive(1, 1, 1, 8'hFF);
    drive(1, 1, 2, 8'hAA);
    drive(1, 1, 2, 8'hBB);
    drive(1, 1, 2, 8'hCC);
    drive(0, 0, 0, 0);
    chk("R4 wrap pointer", int'(ramAddr), 16'h0001);
    drive(1, 1, 0, 8'hFE);
    drive(1, 1, 1, 8'hFF);
    drive(1, 0, 2, 0);
    drive(1, 0, 2, 0);
    drive(1, 0, 2, 0);
    // R5: no increment
    drive(1, 1, 3, 8'h00);
    drive(1, 1, 0, 8'h10);
    drive(1, 1, 1, 8'h00);
    drive(1, 1, 2, 8'h55);
    drive(1, 0, 2, 0);
    drive(1, 0, 2, 0);
    drive(0, 0, 0, 0);
    chk("R5 pointer held", int'(ramAddr), 16'h0010);
    // R10: register readback
    drive(1, 0, 0, 0);
    drive(1, 0, 1, 0);
    drive(1, 0, 3, 0);
    // R6: run and bypass
    drive(1, 1, 3, 8'h05);
    drive(1, 0, 3, 0);
    // R7: doorbell raise, ack, collision
    drive(1, 1, 3, 8'h0D);
    idle(2);
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0);
    drive(1, 1, 3, 8'h0D, 0, 0, 1);
    drive(1, 0, 3, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    // R8: flags, clear, write-zero, set-over-clear
    drive(0, 0, 0, 0, 1, 0);
    drive(1, 0, 3, 0);
    drive(1, 1, 3, 8'h13);
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 1, 3, 8'h03);
    drive(1, 0, 3, 0);
    drive(1, 1, 3, 8'h23, 0, 1);
    drive(1, 0, 3, 0);
    drive(1, 1, 3, 8'h33, 1, 0);
    drive(1, 0, 3, 0);
    drive(1, 1, 3, 8'h33);
    drive(1, 0, 3, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      drive(r[0], r[1], r[3:2], r[15:8], r[20:18] == 3'd0, r[23:21] == 3'd0, r[26:25] == 2'd0);
    end
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule